// File: doc/BRIEF.md
# Throttled Prefetch Buffer

A small fully associative buffer placed between a pointer-chasing prefetch engine and the lookup port of a CPU. The engine pushes prefetched cache blocks in, each tagged with its block address. The CPU presents addresses and takes any block that matches, and taking a block releases its slot. Every slot carries an availability flag. Together these flags act as a producer/consumer throttle, so the buffer never replaces an old block to make room.

When no slot is available, the buffer raises a registered stall output and the engine suspends. The stall drops on the clock edge after the CPU takes a block. A CPU lookup that finds nothing raises a wake pulse in the same cycle, which restarts a suspended engine further down the memory hierarchy.

Top module: `tpb`

## Requirements
- R1: After reset every slot is available, `stall` is 0, and no lookup hits.
- R2: A fill whose address is not held is stored in an available slot. A fill that arrives while no slot is available, with no block taken in the same cycle, is dropped, and a later lookup of its address misses.
- R3: A fill whose address is already held overwrites that slot's data and takes no second slot. A lookup returns the newest data, and once that block is taken a repeat lookup misses.
- R4: A lookup that matches a held address drives `hit`=1 and the block on `hit_data` in the same cycle. The slot becomes available at the next edge, so a repeat lookup of the same address misses.
- R5: `wake` is 1 exactly in cycles where `lk_valid`=1 and the lookup misses. A lookup does not see a fill presented in the same cycle.
- R6: `stall` is a register. It reads 1 from the edge after which no slot is available, and 0 while at least one slot is available.
- R7: When `stall` is 1 and a block is taken with no fill in that cycle, `stall` reads 0 after the next edge.
- R8: When all slots are held and a take and a new-address fill happen in the same cycle, the take is applied first. The fill is stored and `stall` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_valid | input | 1 | Engine presents a prefetched block |
| fl_addr | input | ADDR_W | Block address of the fill |
| fl_data | input | DATA_W | Block contents of the fill |
| lk_valid | input | 1 | CPU presents a lookup |
| lk_addr | input | ADDR_W | Block address looked up |
| hit | output | 1 | Lookup matched a held block |
| hit_data | output | DATA_W | Data of the matched block |
| wake | output | 1 | Lookup missed; restarts a lower-level engine |
| stall | output | 1 | Registered: no slot available, engine must suspend |

## Verification
On every cycle the assertions check the following. A hit and a wake are never raised together. A wake only comes with a presented lookup. `stall` only rises after a fill. A take with no fill clears `stall` and cannot hit the same address again in the next cycle. Other behaviour can only be shown through the bench's scenarios: the data returned after an in-place overwrite, the dropping of a fill into a full buffer, the take-first ordering when the buffer is full, and the exact edge on which `stall` rises as the last slot is filled.

// File: rtl/tpb.sv
module tpb #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_valid,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [DATA_W-1:0] fl_data,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              wake,
  output logic              stall
);
  logic [ENTRIES-1:0] avail, take, match, place, avail_nx;
  logic [ADDR_W-1:0]  tag  [ENTRIES];
  logic [DATA_W-1:0]  blk  [ENTRIES];

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      take[i]  = lk_valid && !avail[i] && tag[i] == lk_addr;
      match[i] = fl_valid && !avail[i] && !take[i] && tag[i] == fl_addr;
      if (take[i]) hit_data = blk[i];
    end
  end

  assign hit  = |take;
  assign wake = lk_valid && !hit;

  always_comb begin
    logic found;
    found = 1'b0;
    place = '0;
    if (fl_valid && !(|match)) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!found && (avail[i] || take[i])) begin
          place[i] = 1'b1;
          found    = 1'b1;
        end
      end
    end
  end

  assign avail_nx = (avail | take) & ~place;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail <= '1;
      stall <= 1'b0;
    end else begin
      avail <= avail_nx;
      stall <= ~|avail_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (place[i] || match[i]) begin
        tag[i] <= fl_addr;
        blk[i] <= fl_data;
      end
    end
  end
endmodule

// File: rtl/tpb_chk.sv
module tpb_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_valid,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              hit,
  input logic              wake,
  input logic              stall
);
  // R4 R5: a hit and a wake are exclusive
  a_r5_hit_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && wake));
  // R5: wake only with a lookup
  a_r5_wake_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> lk_valid);
  // R6: stall only rises after a fill
  a_r6_rise_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(fl_valid));
  // R7: a take without a fill frees a slot
  a_r7_take_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fl_valid) |=> !stall);
  // R4: a taken block cannot be hit again next cycle
  a_r4_consumed_once: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fl_valid) |=> !(hit && lk_addr == $past(lk_addr)));
endmodule

bind tpb tpb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .lk_valid(lk_valid),
  .lk_addr(lk_addr), .hit(hit), .wake(wake), .stall(stall)
);

// File: tb/tpb_tb.sv
module tpb_tb;
  localparam int N = 32;
  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic          fv;
    logic [AW-1:0] fa;
    logic [DW-1:0] fd;
    logic          lv;
    logic [AW-1:0] la;
    logic          eh;
    logic [DW-1:0] ed;
    logic          ew;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0100, 32'hA0, 1'b1, 16'h0200, 1'b0, 32'h0,  1'b1},
    '{1'b0, 16'h0000, 32'h0,  1'b1, 16'h0100, 1'b1, 32'hA0, 1'b0},
    '{1'b0, 16'h0000, 32'h0,  1'b1, 16'h0100, 1'b0, 32'h0,  1'b1},
    '{1'b1, 16'h0110, 32'hB0, 1'b0, 16'h0000, 1'b0, 32'h0,  1'b0},
    '{1'b1, 16'h0110, 32'hB1, 1'b0, 16'h0000, 1'b0, 32'h0,  1'b0},
    '{1'b0, 16'h0000, 32'h0,  1'b1, 16'h0110, 1'b1, 32'hB1, 1'b0},
    '{1'b0, 16'h0000, 32'h0,  1'b1, 16'h0110, 1'b0, 32'h0,  1'b1},
    '{1'b1, 16'h0120, 32'hC0, 1'b1, 16'h0120, 1'b0, 32'h0,  1'b1},
    '{1'b0, 16'h0000, 32'h0,  1'b1, 16'h0120, 1'b1, 32'hC0, 1'b0},
    '{1'b0, 16'h0000, 32'h0,  1'b0, 16'h0000, 1'b0, 32'h0,  1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic fl_valid = 0, lk_valid = 0;
  logic [AW-1:0] fl_addr = '0, lk_addr = '0;
  logic [DW-1:0] fl_data = '0;
  logic hit, wake, stall;
  logic [DW-1:0] hit_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tpb #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .fl_addr(fl_addr),
    .fl_data(fl_data), .lk_valid(lk_valid), .lk_addr(lk_addr), .hit(hit),
    .hit_data(hit_data), .wake(wake), .stall(stall)
  );

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                       input logic lv, input logic [AW-1:0] la);
    @(negedge clk);
    fl_valid = fv; fl_addr = fa; fl_data = fd;
    lk_valid = lv; lk_addr = la;
    #1;
  endtask

  task automatic edge_and_idle();
    @(posedge clk);
    #1;
    fl_valid = 0; lk_valid = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(stall == 0, "R1 stall after reset", stall, 0);
    drive(0, 0, 0, 1, 16'h0100);
    chk(hit == 0, "R1 no hit after reset", hit, 0);
    edge_and_idle();

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].fv, VEC[v].fa, VEC[v].fd, VEC[v].lv, VEC[v].la);
      chk(hit == VEC[v].eh, $sformatf("R4 hit vec %0d", v), hit, VEC[v].eh);
      if (VEC[v].eh) chk(hit_data == VEC[v].ed, $sformatf("R3 data vec %0d", v), hit_data, VEC[v].ed);
      chk(wake == VEC[v].ew, $sformatf("R5 wake vec %0d", v), wake, VEC[v].ew);
      edge_and_idle();
      chk(stall == 0, $sformatf("R6 stall vec %0d", v), stall, 0);
    end

    for (int i = 0; i < N; i++) begin
      drive(1, AW'(16'h1000 + i), DW'(i + 32'h50), 0, 0);
      edge_and_idle();
      chk(stall == (i == N - 1), $sformatf("R6 stall after fill %0d", i), stall, (i == N - 1));
    end

    drive(1, 16'h2000, 32'hDEAD, 0, 0);
    edge_and_idle();
    chk(stall == 1, "R2 stall held on dropped fill", stall, 1);

    drive(0, 0, 0, 1, 16'h1005);
    chk(hit == 1 && hit_data == 32'h55, "R4 take while full", hit_data, 32'h55);
    edge_and_idle();
    chk(stall == 0, "R7 stall released", stall, 0);

    drive(0, 0, 0, 1, 16'h2000);
    chk(hit == 0 && wake == 1, "R2 dropped fill absent", hit, 0);
    edge_and_idle();

    drive(1, 16'h2001, 32'h77, 0, 0);
    edge_and_idle();
    chk(stall == 1, "R6 stall on refill", stall, 1);

    drive(1, 16'h2002, 32'h88, 1, 16'h1000);
    chk(hit == 1 && hit_data == 32'h50, "R8 take with fill", hit_data, 32'h50);
    edge_and_idle();
    chk(stall == 1, "R8 stall stays", stall, 1);

    drive(0, 0, 0, 1, 16'h2002);
    chk(hit == 1 && hit_data == 32'h88, "R8 fill stored", hit_data, 32'h88);
    edge_and_idle();
    chk(stall == 0, "R7 stall released again", stall, 0);

    drive(0, 0, 0, 1, 16'h2001);
    chk(hit == 1 && hit_data == 32'h77, "R2 refill stored", hit_data, 32'h77);
    edge_and_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule